// File: doc/BRIEF.md
# Posit quire dot-product accumulator

This block sums dot products of 16-bit posits (one exponent bit) with no loss of precision. Every multiply-accumulate decodes both operands, forms their full product and adds or subtracts it into a 128-bit two's-complement fixed-point register, the quire. The least significant quire bit weighs 2^-56, the square of the smallest posit. Nothing is rounded while products are summed. A separate round command turns the current quire value into one posit using round-to-nearest. It does not disturb the quire, so partial sums can be read out while accumulation goes on.

Commands arrive over a valid/ready handshake and only one is in flight at a time. A command is accepted on a clock edge where `cmdValid` and `cmdReady` are both high. It executes on the next edge, and `resDone` pulses for one cycle after that. A not-a-real operand poisons the accumulation until the next clear.

Top module: `posit_quire_mac`

## Requirements
- R1: While reset is held and right after it, `cmdReady` is 1, `resDone` is 0 and `resPosit` is 0x0000.
- R2: Command codes on `cmdOp`: 0 clears, 1 multiply-accumulates `opA`×`opB`, 2 rounds the quire to `resPosit`, 3 does nothing. After an accept edge, `cmdReady` is 0 for the following cycle, and `resDone` is 1 for exactly one cycle, starting two edges after the accept. Code 3 leaves the quire and `resPosit` unchanged.
- R3: Operand decoding: a negative word is two's-complemented first. The run of identical bits after the sign gives the regime k: m−1 for m ones, −m for m zeros. The bit after the terminator is the exponent e. The following bits are the fraction, with missing bits read as zero. The value is (1.fraction)·2^(2k+e). For example, 0x5801 is k=0, e=1, fraction 0x801. Rounding 0x5801×0x4000 gives 0x5801, and 0xA7FF×0x4000 gives 0xA7FF.
- R4: Products are accumulated exactly. The sequence 1·1 + minpos·minpos − 1·1 leaves 2^-56 in the quire, not zero.
- R5: A clear sets the quire to zero, so a following round gives 0x0000.
- R6: Rounding is to nearest on the encoded bit pattern, with ties going to an even last bit. 1+2^-13 gives 0x4000, 1+3·2^-13 gives 0x4002, and 1+2^-13+2^-20 gives 0x4001.
- R7: A quire magnitude above maxpos (2^28) rounds to 0x7FFF if positive and to 0x8001 if negative.
- R8: A nonzero quire magnitude below minpos (2^-28) rounds to 0x0001 if positive and to 0xFFFF if negative, never to zero.
- R9: An operand of 0x0000 contributes nothing to the quire.
- R10: An operand of 0x8000 (not-a-real) makes every later round give 0x8000 until the next clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Block can accept a command |
| cmdOp | input | 2 | Command code (see R2) |
| opA | input | 16 | First posit operand |
| opB | input | 16 | Second posit operand |
| resDone | output | 1 | One-cycle completion strobe |
| resPosit | output | 16 | Result of the latest round command |

## Verification
The bench goes after the regime decoder with the longest and shortest runs and with negative operands. A wrong run count would shift every product by a power of four. Tie vectors built from 2^-13 and 2^-20 addends separate ties-to-even from plain round-half-up and from truncation; a design that ignored the sticky bits would return 0x4000 instead of 0x4001. Cancellation down to 2^-56 exposes any accumulator that rounds each product, because such a design returns zero. Overflow and underflow vectors show whether the result saturates to maxpos or minpos or instead wraps or flushes to zero. A not-a-real operand followed by valid products checks that the poison state holds until the clear and goes away after it.

// File: rtl/posit_qa_pkg.sv
package posit_qa_pkg;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_MAC   = 2'd1,
    OP_ROUND = 2'd2,
    OP_NONE  = 2'd3
  } qa_op_e;

  typedef struct packed {
    logic loadOps;
    logic clearQ;
    logic accQ;
    logic convQ;
  } qa_strobe_t;

endpackage

// File: rtl/posit_qa_decode.sv
module posit_qa_decode #(
  parameter int NBITS = 16,
  parameter int ES    = 1,
  parameter int SCW   = 7
) (
  input  logic [NBITS-1:0]      word,
  output logic                  isNar,
  output logic                  sign,
  output logic signed [SCW-1:0] scale,
  output logic [NBITS-3-ES:0]   sig
);
  localparam int FRAC_W = NBITS - 3 - ES;
  localparam int MAXSC  = (NBITS - 2) * (1 << ES);

  logic [NBITS-2:0] body;
  logic [NBITS-4:0] rest;
  logic [ES-1:0]    expBits;
  logic [FRAC_W-1:0] frac;
  logic             isZero;
  logic             stop;
  int               run;
  int               k;

  always_comb begin
    isZero = (word == '0);
    isNar  = (word == {1'b1, {(NBITS-1){1'b0}}});
    sign   = word[NBITS-1];
    body   = (NBITS-1)'(sign ? -word : word);
    run    = 0;
    stop   = 1'b0;
    for (int i = NBITS - 2; i >= 0; i--) begin
      if (!stop && body[i] == body[NBITS-2]) run++;
      else stop = 1'b1;
    end
    // bits after the run and its terminator, left aligned, zero filled
    rest    = body[NBITS-4:0] << (run - 1);
    expBits = rest[NBITS-4 -: ES];
    frac    = rest[FRAC_W-1:0];
    k       = body[NBITS-2] ? run - 1 : -run;
    scale   = SCW'(k * (1 << ES) + int'(expBits));
    sig     = (isZero || isNar) ? '0 : {1'b1, frac};
  end

  always_comb begin
    if (!isZero && !isNar) begin
      a_r3_scale_range: assert (int'(scale) <= MAXSC && int'(scale) >= -MAXSC);
    end
  end

endmodule

// File: rtl/posit_qa_ctrl.sv
module posit_qa_ctrl
  import posit_qa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  output logic       cmdReady,
  output qa_strobe_t strb,
  output logic       resDone
);
  logic   busy;
  qa_op_e opHeld;
  logic   fire;

  assign cmdReady = !busy;
  assign fire     = cmdValid && !busy;

  always_comb begin
    strb.loadOps = fire;
    strb.clearQ  = busy && (opHeld == OP_CLEAR);
    strb.accQ    = busy && (opHeld == OP_MAC);
    strb.convQ   = busy && (opHeld == OP_ROUND);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      opHeld  <= OP_CLEAR;
      resDone <= 1'b0;
    end else begin
      busy    <= fire;
      resDone <= busy;
      if (fire) opHeld <= qa_op_e'(cmdOp);
    end
  end

  a_r2_one_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady |=> !cmdReady);
  a_r2_done_latency: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady |-> ##2 resDone);
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resDone |=> !resDone);

endmodule

// File: rtl/posit_qa_datapath.sv
module posit_qa_datapath
  import posit_qa_pkg::*;
#(
  parameter int NBITS = 16,
  parameter int ES    = 1,
  parameter int QW    = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  qa_strobe_t       strb,
  input  logic [NBITS-1:0] opA,
  input  logic [NBITS-1:0] opB,
  output logic [NBITS-1:0] resPosit
);
  localparam int FRAC_W = NBITS - 3 - ES;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int MAXSC  = (NBITS - 2) * (1 << ES);
  localparam int QLSB   = 2 * MAXSC;
  localparam int SCW    = $clog2(MAXSC + 1) + 2;
  localparam int EXT_W  = QW + 2 * FRAC_W;
  localparam int TAIL_W = ES + QW - 1;
  localparam int BODY_W = QW + 2 * NBITS;
  localparam logic [NBITS-1:0] NAR    = {1'b1, {(NBITS-1){1'b0}}};
  localparam logic [NBITS-1:0] MAXPOS = {1'b0, {(NBITS-1){1'b1}}};
  localparam logic [NBITS-1:0] MINPOS = NBITS'(1);

  logic [NBITS-1:0]      opHeld [2];
  logic                  dNar   [2];
  logic                  dSign  [2];
  logic signed [SCW-1:0] dScale [2];
  logic [SIG_W-1:0]      dSig   [2];

  logic [QW-1:0]    quire;
  logic             narFlag;
  logic [NBITS-1:0] resReg;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_dec
      posit_qa_decode #(.NBITS(NBITS), .ES(ES), .SCW(SCW)) u_dec (
        .word (opHeld[g]),
        .isNar(dNar[g]),
        .sign (dSign[g]),
        .scale(dScale[g]),
        .sig  (dSig[g])
      );
    end
  endgenerate

  // exact product aligned to the quire grid
  logic [2*SIG_W-1:0] prod;
  logic [EXT_W-1:0]   ext;
  logic [QW-1:0]      addend;
  logic               prodNeg;

  always_comb begin
    prod    = dSig[0] * dSig[1];
    prodNeg = dSign[0] ^ dSign[1];
    ext     = EXT_W'(prod) << (int'(dScale[0]) + int'(dScale[1]) + QLSB);
    addend  = QW'(ext >> (2 * FRAC_W));
  end

  // quire to posit, one rounding step
  logic              qNeg;
  logic [QW-1:0]     mag;
  logic [ES-1:0]     eBits;
  logic [QW-2:0]     fracBits;
  logic [TAIL_W-1:0] tail;
  logic [BODY_W-1:0] regMask;
  logic [BODY_W-1:0] body;
  logic [NBITS-2:0]  keep;
  logic [NBITS-2:0]  rounded;
  logic              guardBit;
  logic              stickyBit;
  logic [NBITS-1:0]  magOut;
  logic [NBITS-1:0]  convOut;
  int                lead;
  int                s;
  int                k;

  always_comb begin
    qNeg = quire[QW-1];
    mag  = qNeg ? -quire : quire;
    lead = 0;
    for (int i = 0; i < QW; i++) if (mag[i]) lead = i;
    s        = lead - QLSB;
    k        = s >>> ES;
    eBits    = ES'(s - k * (1 << ES));
    fracBits = (QW-1)'(mag << (QW - 1 - lead));
    tail     = {eBits, fracBits};
    regMask  = (k >= 0) ? ~({BODY_W{1'b1}} >> (k + 1))
                        : ({1'b1, {(BODY_W-1){1'b0}}} >> (-k));
    body     = ({tail, {(BODY_W-TAIL_W){1'b0}}} >> ((k >= 0) ? k + 2 : 1 - k)) | regMask;
    keep      = body[BODY_W-1 -: NBITS-1];
    guardBit  = body[BODY_W-NBITS];
    stickyBit = |body[BODY_W-NBITS-1:0];
    rounded   = keep + (NBITS-1)'(guardBit && (stickyBit || keep[0]));
    if (s > MAXSC)       magOut = MAXPOS;
    else if (s < -MAXSC) magOut = MINPOS;
    else                 magOut = {1'b0, rounded};
    if (narFlag)         convOut = NAR;
    else if (mag == '0)  convOut = '0;
    else                 convOut = qNeg ? -magOut : magOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opHeld[0] <= '0;
      opHeld[1] <= '0;
      quire     <= '0;
      narFlag   <= 1'b0;
      resReg    <= '0;
    end else begin
      if (strb.loadOps) begin
        opHeld[0] <= opA;
        opHeld[1] <= opB;
      end
      if (strb.clearQ) begin
        quire   <= '0;
        narFlag <= 1'b0;
      end else if (strb.accQ) begin
        if (dNar[0] || dNar[1]) narFlag <= 1'b1;
        else quire <= prodNeg ? quire - addend : quire + addend;
      end
      if (strb.convQ) resReg <= convOut;
    end
  end

  assign resPosit = resReg;

  a_r10_nar_sticky: assert property (@(posedge clk) disable iff (!rstN)
    strb.convQ && narFlag |=> resPosit == NAR);
  a_r8_no_flush: assert property (@(posedge clk) disable iff (!rstN)
    strb.convQ && !narFlag && quire != '0 |=> resPosit != '0);
  a_r7_sign_follows: assert property (@(posedge clk) disable iff (!rstN)
    strb.convQ && !narFlag && quire != '0 |=> resPosit[NBITS-1] == $past(quire[QW-1]));
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearQ |=> quire == '0 && !narFlag);

endmodule

// File: rtl/posit_quire_mac.sv
module posit_quire_mac
  import posit_qa_pkg::*;
#(
  parameter int NBITS = 16,
  parameter int ES    = 1,
  parameter int QW    = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [1:0]       cmdOp,
  input  logic [NBITS-1:0] opA,
  input  logic [NBITS-1:0] opB,
  output logic             resDone,
  output logic [NBITS-1:0] resPosit
);
  qa_strobe_t strb;

  posit_qa_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .cmdReady(cmdReady),
    .strb    (strb),
    .resDone (resDone)
  );

  posit_qa_datapath #(.NBITS(NBITS), .ES(ES), .QW(QW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .opA     (opA),
    .opB     (opB),
    .resPosit(resPosit)
  );

endmodule

// File: tb/posit_quire_mac_test.sv
module posit_quire_mac_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdOp = 2'd0;
  logic [15:0] opA = 16'h0;
  logic [15:0] opB = 16'h0;
  logic        resDone;
  logic [15:0] resPosit;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  real refSum = 0.0;
  bit  refNar = 1'b0;

  typedef struct {
    bit          chk;
    logic [15:0] expVal;
    string       tag;
  } sb_item_t;
  sb_item_t sbq[$];

  always #4 clk = ~clk;

  posit_quire_mac uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .opA(opA), .opB(opB), .resDone(resDone), .resPosit(resPosit)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // reference posit value
  function automatic real pval(input logic [15:0] p);
    logic [15:0] a;
    logic        r0;
    int          i, m, k, e, sc;
    real         f, w, v;
    if (p == 16'h0) return 0.0;
    a  = p[15] ? -p : p;
    r0 = a[14];
    m  = 0;
    i  = 14;
    while (i >= 0 && a[i] == r0) begin m++; i--; end
    k = r0 ? m - 1 : -m;
    i--;
    e = 0;
    if (i >= 0) begin e = int'(a[i]); i--; end
    f = 1.0; w = 0.5;
    while (i >= 0) begin
      if (a[i]) f = f + w;
      w = w / 2.0;
      i--;
    end
    sc = 2 * k + e;
    v  = f;
    if (sc > 0) repeat (sc) v = v * 2.0;
    else repeat (-sc) v = v / 2.0;
    return p[15] ? -v : v;
  endfunction

  // reference rounding, valid where the guard position is a fraction bit
  function automatic logic [15:0] enc(input real x);
    real a, d1, d2;
    int  lo, hi, mid;
    logic [15:0] r;
    a = (x < 0.0) ? -x : x;
    if (a == 0.0) return 16'h0;
    if (a >= pval(16'h7FFF)) r = 16'h7FFF;
    else if (a <= pval(16'h0001)) r = 16'h0001;
    else begin
      lo = 1; hi = 32767;
      while (hi - lo > 1) begin
        mid = (lo + hi) / 2;
        if (pval(16'(mid)) <= a) lo = mid; else hi = mid;
      end
      d1 = a - pval(16'(lo));
      d2 = pval(16'(hi)) - a;
      if (d1 < d2) r = 16'(lo);
      else if (d2 < d1) r = 16'(hi);
      else r = (lo % 2 == 1) ? 16'(hi) : 16'(lo);
    end
    return (x < 0.0) ? -r : r;
  endfunction

  task automatic issue(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                       input bit chk, input logic [15:0] expv, input string tag);
    sb_item_t it;
    it.chk = chk; it.expVal = expv; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; opA = a; opB = b;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    check(cmdReady == 1'b0, "R2 ready low after accept", 16'(cmdReady), 16'h0);
    @(negedge clk);
    check(resDone == 1'b1, "R2 done two edges after accept", 16'(resDone), 16'h1);
  endtask

  task automatic doClear();
    refSum = 0.0; refNar = 1'b0;
    issue(2'd0, 16'h0, 16'h0, 1'b0, 16'h0, "clear");
  endtask

  task automatic doMac(input logic [15:0] a, input logic [15:0] b);
    if (a == 16'h8000 || b == 16'h8000) refNar = 1'b1;
    else refSum = refSum + pval(a) * pval(b);
    issue(2'd1, a, b, 1'b0, 16'h0, "mac");
  endtask

  task automatic convModel(input string tag);
    issue(2'd2, 16'h0, 16'h0, 1'b1, refNar ? 16'h8000 : enc(refSum), tag);
  endtask

  task automatic convExp(input logic [15:0] expv, input string tag);
    issue(2'd2, 16'h0, 16'h0, 1'b1, expv, tag);
  endtask

  // scoreboard monitor
  logic prevDone = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (resDone && prevDone) check(1'b0, "R2 done lasts one cycle", 16'h1, 16'h0);
      if (resDone) begin
        if (sbq.size() == 0) check(1'b0, "R2 unexpected done", 16'h1, 16'h0);
        else begin
          sb_item_t it;
          it = sbq.pop_front();
          if (it.chk) check(resPosit == it.expVal, it.tag, resPosit, it.expVal);
        end
      end
    end
    prevDone = resDone;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmdReady == 1'b1, "R1 ready in reset", 16'(cmdReady), 16'h1);
    check(resDone == 1'b0, "R1 done in reset", 16'(resDone), 16'h0);
    check(resPosit == 16'h0, "R1 result in reset", resPosit, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReady == 1'b1 && resDone == 1'b0, "R1 idle after reset", {cmdReady, resDone}, 16'h2);

    // R5: clear discards an accumulated value
    doMac(16'h4800, 16'h4800);
    doClear();
    convExp(16'h0000, "R5 round after clear");

    // R3: decode examples
    doMac(16'h5801, 16'h4000);
    convExp(16'h5801, "R3 0x5801 times one");
    convModel("R3 0x5801 model");
    doClear();
    doMac(16'hA7FF, 16'h4000);
    convExp(16'hA7FF, "R3 negative operand");
    doClear();
    doMac(16'h7FFF, 16'h0001);
    convExp(16'h4000, "R3 longest runs maxpos*minpos");

    // R6: ties and sticky
    doClear();
    doMac(16'h4000, 16'h4000);
    doMac(16'h00C0, 16'h4000);
    convExp(16'h4000, "R6 tie rounds to even down");
    doMac(16'h00C0, 16'h4000);
    doMac(16'h00C0, 16'h4000);
    convExp(16'h4002, "R6 tie rounds to even up");
    doClear();
    doMac(16'h4000, 16'h4000);
    doMac(16'h00C0, 16'h4000);
    doMac(16'h0010, 16'h4000);
    convExp(16'h4001, "R6 above tie rounds up");

    // general dot products against the model
    doClear();
    doMac(16'h4A37, 16'h3B21);
    doMac(16'h52C9, 16'hB6E5);
    convModel("R6 dot product pair");
    doMac(16'h4123, 16'h6001);
    convModel("R6 dot product three");
    doMac(16'hC5A0, 16'h4F0F);
    convModel("R6 dot product four");
    issue(2'd3, 16'h7FFF, 16'h7FFF, 1'b0, 16'h0, "nop");
    convModel("R2 code 3 changes nothing");

    // R7: saturation
    doClear();
    doMac(16'h7FFF, 16'h7FFF);
    convExp(16'h7FFF, "R7 positive saturation");
    doClear();
    doMac(16'h8001, 16'h7FFF);
    convExp(16'h8001, "R7 negative saturation");

    // R8: tiny values
    doClear();
    doMac(16'h0001, 16'h0001);
    convExp(16'h0001, "R8 positive minpos");
    doClear();
    doMac(16'hFFFF, 16'h0001);
    convExp(16'hFFFF, "R8 negative minpos");

    // R4: exact cancellation
    doClear();
    doMac(16'h4000, 16'h4000);
    doMac(16'h0001, 16'h0001);
    doMac(16'hC000, 16'h4000);
    convExp(16'h0001, "R4 exact residue survives");

    // R9: zero operand
    doClear();
    doMac(16'h4800, 16'h4000);
    doMac(16'h0000, 16'h7FFF);
    doMac(16'h7FFF, 16'h0000);
    convExp(16'h4800, "R9 zero adds nothing");

    // R10: not-a-real
    doClear();
    doMac(16'h8000, 16'h4000);
    doMac(16'h4000, 16'h4000);
    convExp(16'h8000, "R10 poisoned");
    convExp(16'h8000, "R10 still poisoned");
    doClear();
    convExp(16'h0000, "R10 clear removes poison");
    doMac(16'h4000, 16'h4000);
    convExp(16'h4000, "R10 valid after clear");

    repeat (5) @(negedge clk);
    check(sbq.size() == 0, "R2 all commands completed", 16'(sbq.size()), 16'h0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "R2 watchdog expired", 16'h0, 16'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule